// File: doc/BRIEF.md
# Bus Mode and Pin-Function Controller

This block keeps the operating mode of a microcontroller and the settings that decide how its shared pins are used. Two 8-bit ports either stay general I/O or carry a multiplexed address/data bus. An 8-pin control port can hand single pins to bus-control jobs: a free-running bus clock, a read/write strobe, a low-byte strobe and two pipe-status lines. Software reaches two registers through a simple write/read interface. The block turns the registered state into a function code, an output enable and a pull-up enable for every control-port pin, plus a bus flag for each 8-bit port.

The mode is loaded from the reset mode inputs while reset is held. A small write-permission machine decides whether the mode register may still be written. Its states are `WR_ONCE` (normal single-chip: one write allowed), `WR_FREE` (special single-chip: any number of writes) and `WR_LOCKED` (no writes). Reset enters `WR_ONCE`, `WR_FREE` or `WR_LOCKED` depending on the reset mode. The transition *spend* goes from `WR_ONCE` to `WR_LOCKED` on any mode-register write. The transition *stay* keeps `WR_FREE` and `WR_LOCKED` where they are. Only a reset leaves `WR_LOCKED`.

Register map (address input `addr_i`):
- Address 0, mode register: bits [1:0] mode (00 normal single-chip, 01 special single-chip, 10 expanded wide, 11 expanded narrow), bit 2 internal-access visibility. The other bits read 0.
- Address 1, pin-control register: bit 0 clock-off (1 = bus clock not driven unless forced), bit 1 read/write enable, bit 2 low-byte strobe enable, bit 3 pipe-status enable. The other bits read 0.

Top module: `bus_mode_ctrl`

## Requirements
- R1: After reset the mode register reads `{visibility=0, mode=rst_mode_i}`. The pin-control register reads 0x01 in the two single-chip modes and 0x00 in the two expanded modes.
- R2: After a reset into normal single-chip mode, the first mode-register write takes effect on the next clock edge. Every later mode-register write is ignored until reset. A read always returns the current value.
- R3: After a reset into special single-chip mode, every mode-register write takes effect.
- R4: After a reset into either expanded mode, mode-register writes are ignored.
- R5: While the mode is normal single-chip, pin-control bits 3..1 read 0 and writes of 1 to them are ignored. Bit 0 stays writable.
- R6: A mode-register write that selects normal single-chip clears pin-control bits 3..1 on the same clock edge.
- R7: `porta_bus_o` is 1 exactly in the two expanded modes. `portb_bus_o` is 1 exactly in expanded wide mode.
- R8: Control pin 4 has function code 1 (bus clock) when the mode is expanded or clock-off is 0, in any mode. Otherwise its code is 0 (general I/O).
- R9: Only in expanded modes: pin 2 has code 2 when read/write enable is set, and pin 3 has code 2 when low-byte strobe enable is set. Otherwise both have code 0.
- R10: Pins 6 and 5 have code 3 (pipe status) exactly when the mode is expanded and pipe-status enable is set.
- R11: For every control pin, the output enable is 1 and the pull-up is 0 when its code is nonzero. When its code is 0, the output enable is 0 and the pull-up is 1. Pins 1 and 0 always have code 0. Function codes sit at bits [2p+1:2p] of `ctl_func_o` for pin p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_mode_i | input | 2 | Mode loaded while reset is held |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select (0 mode, 1 pin-control) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| mode_o | output | 2 | Current mode |
| vis_o | output | 1 | Internal-access visibility |
| porta_bus_o | output | 1 | First 8-bit port carries the multiplexed bus |
| portb_bus_o | output | 1 | Second 8-bit port carries the multiplexed bus |
| ctl_func_o | output | 16 | 2-bit function code per control pin |
| ctl_oe_o | output | 8 | Output enable per control pin |
| ctl_pu_o | output | 8 | Pull-up enable per control pin |

## Verification
Every register write lands on the clock edge that samples `wr_en_i`. The pin functions, enables, bus flags and read data are combinational from the registers, so they are due one edge after the write, or at once for a change of `addr_i`. The bench drives inputs on the falling edge and samples on the next falling edge, just after the edge that is expected to move the result. Reads are sampled one time unit after the address changes, within the low half of the clock.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    typedef enum logic [1:0] {
        MODE_NSC = 2'b00,
        MODE_SSC = 2'b01,
        MODE_XW  = 2'b10,
        MODE_XN  = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        FN_GPIO = 2'd0,
        FN_CLK  = 2'd1,
        FN_STRB = 2'd2,
        FN_PIPE = 2'd3
    } pin_fn_e;

    typedef enum logic [1:0] {
        WR_FREE   = 2'd0,
        WR_ONCE   = 2'd1,
        WR_LOCKED = 2'd2
    } wr_state_e;

    // pin-control register bit positions
    localparam int CB_CLKOFF = 0;
    localparam int CB_RW     = 1;
    localparam int CB_LSTRB  = 2;
    localparam int CB_PIPE   = 3;
    localparam int CB_W      = 4;

    // control-port pin positions
    localparam int PIN_RW    = 2;
    localparam int PIN_LSTRB = 3;
    localparam int PIN_CLK   = 4;
    localparam int PIN_PIPE0 = 5;
    localparam int PIN_PIPE1 = 6;
    localparam int IN_ONLY_PINS = 2;

    function automatic logic mode_expanded(input logic [1:0] m);
        return m[1];
    endfunction
endpackage

// File: rtl/bmc_mode_fsm.sv
module bmc_mode_fsm
    import bmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rst_mode_i,
    input  logic       mode_wr_i,
    output logic       wr_ok_o,
    output logic       locked_o
);
    wr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_ONCE:   if (mode_wr_i) state_d = WR_LOCKED;
            WR_FREE:   state_d = WR_FREE;
            WR_LOCKED: state_d = WR_LOCKED;
            default:   state_d = WR_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unique case (rst_mode_i)
                MODE_NSC: state_q <= WR_ONCE;
                MODE_SSC: state_q <= WR_FREE;
                default:  state_q <= WR_LOCKED;
            endcase
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        wr_ok_o  = 1'b0;
        locked_o = 1'b0;
        unique case (state_q)
            WR_ONCE, WR_FREE: wr_ok_o  = 1'b1;
            default:          locked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/bmc_regs.sv
module bmc_regs
    import bmc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rst_mode_i,
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_ok_i,
    output logic [1:0]        mode_o,
    output logic              vis_o,
    output logic [CB_W-1:0]   ctl_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [1:0]      mode_q;
    logic            vis_q;
    logic [CB_W-1:0] ctl_q;
    logic            mode_wr, ctl_wr;

    assign mode_wr = wr_en_i && !addr_i && wr_ok_i;
    assign ctl_wr  = wr_en_i && addr_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= rst_mode_i;
            vis_q  <= 1'b0;
            ctl_q  <= '0;
            ctl_q[CB_CLKOFF] <= !mode_expanded(rst_mode_i);
        end else if (mode_wr) begin
            mode_q <= wdata_i[1:0];
            vis_q  <= wdata_i[2];
            if (wdata_i[1:0] == MODE_NSC)
                ctl_q[CB_W-1:1] <= '0;
        end else if (ctl_wr) begin
            ctl_q[CB_CLKOFF] <= wdata_i[CB_CLKOFF];
            if (mode_q == MODE_NSC)
                ctl_q[CB_W-1:1] <= '0;
            else
                ctl_q[CB_W-1:1] <= wdata_i[CB_W-1:1];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i) rdata_o[CB_W-1:0] = ctl_q;
        else        rdata_o[2:0]      = {vis_q, mode_q};
    end

    assign mode_o = mode_q;
    assign vis_o  = vis_q;
    assign ctl_o  = ctl_q;
endmodule

// File: rtl/bmc_pin_resolve.sv
module bmc_pin_resolve
    import bmc_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic [1:0]       mode_i,
    input  logic [CB_W-1:0]  ctl_i,
    output logic             porta_bus_o,
    output logic             portb_bus_o,
    output logic [2*CTL_W-1:0] func_o,
    output logic [CTL_W-1:0] oe_o,
    output logic [CTL_W-1:0] pu_o
);
    logic xp;
    assign xp          = mode_expanded(mode_i);
    assign porta_bus_o = xp;
    assign portb_bus_o = (mode_i == MODE_XW);

    for (genvar p = 0; p < CTL_W; p++) begin : g_pin
        pin_fn_e fn;
        always_comb begin
            fn = FN_GPIO;
            if (p >= IN_ONLY_PINS) begin
                if (p == PIN_CLK && (xp || !ctl_i[CB_CLKOFF])) fn = FN_CLK;
                if (p == PIN_RW && xp && ctl_i[CB_RW])          fn = FN_STRB;
                if (p == PIN_LSTRB && xp && ctl_i[CB_LSTRB])    fn = FN_STRB;
                if ((p == PIN_PIPE0 || p == PIN_PIPE1) && xp && ctl_i[CB_PIPE])
                    fn = FN_PIPE;
            end
        end
        assign func_o[2*p +: 2] = fn;
        assign oe_o[p] = (fn != FN_GPIO);
        assign pu_o[p] = (fn == FN_GPIO);
    end
endmodule

// File: rtl/bus_mode_ctrl.sv
module bus_mode_ctrl
    import bmc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTL_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           rst_mode_i,
    input  logic                 wr_en_i,
    input  logic                 addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [1:0]           mode_o,
    output logic                 vis_o,
    output logic                 porta_bus_o,
    output logic                 portb_bus_o,
    output logic [2*CTL_W-1:0]   ctl_func_o,
    output logic [CTL_W-1:0]     ctl_oe_o,
    output logic [CTL_W-1:0]     ctl_pu_o
);
    logic            wr_ok, wr_locked;
    logic [CB_W-1:0] ctl;

    bmc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_mode_i (rst_mode_i),
        .mode_wr_i  (wr_en_i && !addr_i),
        .wr_ok_o    (wr_ok),
        .locked_o   (wr_locked)
    );

    bmc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_mode_i (rst_mode_i),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .wr_ok_i    (wr_ok),
        .mode_o     (mode_o),
        .vis_o      (vis_o),
        .ctl_o      (ctl),
        .rdata_o    (rdata_o)
    );

    bmc_pin_resolve #(.CTL_W(CTL_W)) u_pins (
        .mode_i      (mode_o),
        .ctl_i       (ctl),
        .porta_bus_o (porta_bus_o),
        .portb_bus_o (portb_bus_o),
        .func_o      (ctl_func_o),
        .oe_o        (ctl_oe_o),
        .pu_o        (ctl_pu_o)
    );
endmodule

// File: rtl/bmc_checks.sv
module bmc_checks
    import bmc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTL_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en_i,
    input logic               addr_i,
    input logic [DATA_W-1:0]  rdata_o,
    input logic [1:0]         mode_o,
    input logic               vis_o,
    input logic               porta_bus_o,
    input logic               portb_bus_o,
    input logic [2*CTL_W-1:0] ctl_func_o,
    input logic [CTL_W-1:0]   ctl_oe_o,
    input logic [CTL_W-1:0]   ctl_pu_o,
    input logic               locked_i
);
    assert_locked_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && locked_i) |=> ($stable(mode_o) && $stable(vis_o)));

    assert_nsc_enables_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_NSC && addr_i) |-> (rdata_o[CB_W-1:1] == '0));

    assert_portb_needs_porta_R7: assert property (@(posedge clk) disable iff (!rst_n)
        portb_bus_o |-> porta_bus_o);

    assert_wide_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_XW) |-> (ctl_func_o[2*PIN_CLK +: 2] == FN_CLK));

    assert_oe_pu_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_oe_o & ctl_pu_o) == '0) && (ctl_oe_o[IN_ONLY_PINS-1:0] == '0));
endmodule

bind bus_mode_ctrl bmc_checks #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .rdata_o     (rdata_o),
    .mode_o      (mode_o),
    .vis_o       (vis_o),
    .porta_bus_o (porta_bus_o),
    .portb_bus_o (portb_bus_o),
    .ctl_func_o  (ctl_func_o),
    .ctl_oe_o    (ctl_oe_o),
    .ctl_pu_o    (ctl_pu_o),
    .locked_i    (wr_locked)
);

// File: tb/tb_bus_mode_ctrl.sv
module tb_bus_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  rst_mode;
    logic        wr_en;
    logic        addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [1:0]  mode;
    logic        vis;
    logic        pa_bus, pb_bus;
    logic [15:0] func;
    logic [7:0]  oe, pu;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rst_mode_i(rst_mode), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .mode_o(mode),
        .vis_o(vis), .porta_bus_o(pa_bus), .portb_bus_o(pb_bus),
        .ctl_func_o(func), .ctl_oe_o(oe), .ctl_pu_o(pu)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected function codes from the requirements (R8, R9, R10, R11)
    function automatic logic [15:0] exp_func(input logic [1:0] m, input logic [3:0] c);
        logic [15:0] f = '0;
        logic xp = m[1];
        if (xp || !c[0]) f[9:8]   = 2'd1;
        if (xp && c[1])  f[5:4]   = 2'd2;
        if (xp && c[2])  f[7:6]   = 2'd2;
        if (xp && c[3])  begin f[11:10] = 2'd3; f[13:12] = 2'd3; end
        return f;
    endfunction

    function automatic logic [7:0] oe_of(input logic [15:0] f);
        logic [7:0] o;
        for (int p = 0; p < 8; p++) o[p] = (f[2*p +: 2] != 2'd0);
        return o;
    endfunction

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; rst_mode = m; wr_en = 1'b0; addr = 1'b0; wdata = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(req, {8'h00, rdata}, {8'h00, exp});
    endtask

    task automatic pins(input string req, input logic [1:0] m, input logic [3:0] c);
        logic [15:0] f = exp_func(m, c);
        chk({req, " func"}, func, f);
        chk({req, " oe R11"}, {8'h00, oe}, {8'h00, oe_of(f)});
        chk({req, " pu R11"}, {8'h00, pu}, {8'h00, ~oe_of(f)});
        chk({req, " bus R7"}, {14'h0, pa_bus, pb_bus}, {14'h0, m[1], m == 2'b10});
    endtask

    task automatic t_reset_nsc;
        do_reset(2'b00);
        rd("R1 mode", 1'b0, 8'h00);
        rd("R1 ctl", 1'b1, 8'h01);
        pins("R1", 2'b00, 4'h1);
    endtask

    task automatic t_nsc_ctl;
        wr(1'b1, 8'h0F);
        rd("R5 enables ignored", 1'b1, 8'h01);
        pins("R5", 2'b00, 4'h1);
        wr(1'b1, 8'h0E);
        rd("R5 clkoff writable", 1'b1, 8'h00);
        pins("R8 single-chip clock", 2'b00, 4'h0);
    endtask

    task automatic t_nsc_once;
        wr(1'b0, 8'h06);
        rd("R2 first write", 1'b0, 8'h06);
        chk("R2 vis", {15'h0, vis}, 16'h1);
        wr(1'b0, 8'h00);
        rd("R2 second write ignored", 1'b0, 8'h06);
        chk("R2 mode port", {14'h0, mode}, 16'h2);
        pins("R8 wide forced clock", 2'b10, 4'h0);
    endtask

    task automatic t_wide_ctl;
        wr(1'b1, 8'h0A);
        rd("R9 ctl readback", 1'b1, 8'h0A);
        pins("R9 R10 rw pipe", 2'b10, 4'hA);
        wr(1'b1, 8'h05);
        pins("R9 lstrb, R8 forced", 2'b10, 4'h5);
    endtask

    task automatic t_narrow;
        do_reset(2'b11);
        rd("R1 narrow mode", 1'b0, 8'h03);
        rd("R1 narrow ctl", 1'b1, 8'h00);
        pins("R7 narrow", 2'b11, 4'h0);
        wr(1'b0, 8'h00);
        rd("R4 locked", 1'b0, 8'h03);
        do_reset(2'b10);
        wr(1'b0, 8'h01);
        rd("R4 wide locked", 1'b0, 8'h02);
    endtask

    task automatic t_special;
        do_reset(2'b01);
        rd("R1 special mode", 1'b0, 8'h01);
        rd("R1 special ctl", 1'b1, 8'h01);
        wr(1'b1, 8'h0E);
        rd("R9 special stores", 1'b1, 8'h0E);
        pins("R9 special no bus functions", 2'b01, 4'hE);
        wr(1'b0, 8'h02);
        rd("R3 write 1", 1'b0, 8'h02);
        pins("R10 wide via special", 2'b10, 4'hE);
        wr(1'b0, 8'h03);
        rd("R3 write 2", 1'b0, 8'h03);
        wr(1'b0, 8'h04);
        rd("R3 write 3", 1'b0, 8'h04);
        rd("R6 enables cleared", 1'b1, 8'h00);
        pins("R6", 2'b00, 4'h0);
    endtask

    initial begin
        rst_n = 1'b0; rst_mode = 2'b00; wr_en = 1'b0; addr = 1'b0; wdata = '0;
        t_reset_nsc();
        t_nsc_ctl();
        t_nsc_once();
        t_wide_ctl();
        t_narrow();
        t_special();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule